// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block holds the sticky status flags of an I2C controller and presents them to a CPU through a small synchronous register bus. The I2C protocol engine reports what happens on the bus through single-cycle event pulses (START, STOP, arbitration lost, NACK received or sent, receive overrun, slave-transmit selection, and so on). It also drives three level inputs: the module soft reset, the digital loopback mode and the current SCL level. Each flag has its own set and clear conditions and its own reset value.

Software reads the flags at one address and clears them by writing ones. At a second address it keeps an interrupt enable mask. A single registered interrupt request is raised whenever any flag is set while its mask bit is set.

Top module: `i2c_stat_irq`

Status bit layout (read at address 0): bit0 arbitration lost, bit1 NACK received, bit2 access ready, bit3 receive ready, bit4 transmit ready, bit5 STOP seen, bit6 slave transmitting, bit7 transmit empty, bit8 receive overrun, bit9 bus busy, bit10 NACK sent. All higher bits are reserved.

## Requirements
- R1: After `rst_n` is released, the status reads 0x0090 (only transmit ready, bit4, and transmit empty, bit7, are set), the mask at address 1 reads 0, and `irq` is 0.
- R2: Writing address 0 clears each of bits 0–6, 9 and 10 whose write-data bit is 1. Zero bits have no effect. Bits 7 and 8 and the reserved bits ignore writes, reserved bits read 0, and any address other than 0 and 1 reads 0.
- R3: If a set event and any clear source for the same flag arrive in one cycle, the flag ends up set.
- R4: Bit6 is set by `ev_slv_tx` and cleared by `ev_start`, `ev_stop` or a write of 1. While `loopback` is 1 it is forced to 0, and this override beats a set event.
- R5: Bit10 is set by `ev_nack_tx` and cleared only by a write of 1 or by a reset.
- R6: Bit9 is set by `ev_start` and cleared by `ev_stop` or a write of 1. While `mod_rst` is 1 it equals the inverse of `scl_in`.
- R7: Bit8 is set by `ev_rx_ovr` and cleared by `rx_rd` (a read of the receive data). Bit5 is set by `ev_stop`, and bits 0–4 are each set by their own event.
- R8: Bit7 is set by `ev_tx_undr` and cleared by `tx_wr`.
- R9: While `mod_rst` is 1, every flag except bit9 holds its R1 value after each clock. The mask register is not affected.
- R10: `irq` equals, one cycle later, the OR over all bits of status AND mask. Writing address 1 loads the mask from `bus_wdata[10:0]`.
- R11: A read strobe in cycle t places the register value as of cycle t on `bus_rdata` from cycle t+1. `bus_rdata` holds that value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| mod_rst | input | 1 | Module soft reset level |
| loopback | input | 1 | Digital loopback mode level |
| scl_in | input | 1 | Current SCL line level |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_nack_rx | input | 1 | NACK received pulse |
| ev_acc_rdy | input | 1 | Register access ready pulse |
| ev_rx_rdy | input | 1 | Receive data ready pulse |
| ev_tx_rdy | input | 1 | Transmit data ready pulse |
| ev_stop | input | 1 | STOP seen pulse |
| ev_start | input | 1 | START seen pulse |
| ev_slv_tx | input | 1 | Acting as slave transmitter pulse |
| ev_tx_undr | input | 1 | Transmit underflow pulse |
| ev_rx_ovr | input | 1 | Receive overrun pulse |
| ev_nack_tx | input | 1 | NACK driven in acknowledge cycle pulse |
| tx_wr | input | 1 | Transmit data register written |
| rx_rd | input | 1 | Receive data register read |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the event inputs are synchronous to `clk` and that `rst_n` is the only asynchronous input. Apart from that, any mix of events, levels and bus strobes in one cycle is legal, including set and clear of the same flag together. The stimulus drives every input just after the falling edge, so it stays inside this assumption. It deliberately overlaps set and clear events, toggles `mod_rst`, `loopback` and `scl_in` at random, and strobes reads and writes on the same address in the same cycle.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
    localparam int NFLAG = 11;

    localparam int F_ARB   = 0;
    localparam int F_NKRX  = 1;
    localparam int F_ACC   = 2;
    localparam int F_RXRDY = 3;
    localparam int F_TXRDY = 4;
    localparam int F_STOP  = 5;
    localparam int F_SLV   = 6;
    localparam int F_TXEMP = 7;
    localparam int F_OVR   = 8;
    localparam int F_BUSY  = 9;
    localparam int F_NKTX  = 10;

    // flags software may clear by writing one
    localparam logic [NFLAG-1:0] W1C_MASK = 11'h67F;
    // values after system reset
    localparam logic [NFLAG-1:0] RST_VAL  = 11'h090;

    typedef struct packed {
        logic set;
        logic clr;
        logic load;
        logic load_val;
    } flag_ctl_t;
endpackage

// File: rtl/i2cst_flag_cell.sv
module i2cst_flag_cell
    import i2cst_pkg::*;
#(
    parameter logic RESET_BIT = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  flag_ctl_t ctl_i,
    output logic      q_o
);
    logic q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (ctl_i.load)      q_d = ctl_i.load_val;
        else if (ctl_i.set)  q_d = 1'b1;
        else if (ctl_i.clr)  q_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= RESET_BIT;
        else        q_q <= q_d;
    end

    assign q_o = q_q;

    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.set && !ctl_i.load) |=> q_o);

    // R9
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.load |=> (q_o == $past(ctl_i.load_val)));
endmodule

// File: rtl/i2cst_bus_if.sv
module i2cst_bus_if #(
    parameter int NFLAG     = 11,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 4,
    parameter int STAT_ADDR = 0,
    parameter int MASK_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    input  logic [NFLAG-1:0]  flags_i,
    output logic [NFLAG-1:0]  w1c_o,
    output logic [NFLAG-1:0]  mask_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);

    typedef struct packed {
        logic [NFLAG-1:0]  mask;
        logic [DATA_W-1:0] rdata;
    } bus_st_t;

    bus_st_t st_d, st_q;
    logic hit_stat, hit_mask;

    always_comb begin
        hit_stat = (addr_i == A_STAT);
        hit_mask = (addr_i == A_MASK);
        st_d     = st_q;
        w1c_o    = (wr_i && hit_stat) ? wdata_i[NFLAG-1:0] : '0;
        if (wr_i && hit_mask) st_d.mask = wdata_i[NFLAG-1:0];
        if (rd_i) begin
            st_d.rdata = '0;
            if (hit_stat)      st_d.rdata[NFLAG-1:0] = flags_i;
            else if (hit_mask) st_d.rdata[NFLAG-1:0] = st_q.mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o  = st_q.mask;
    assign rdata_o = st_q.rdata;

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DATA_W-1:NFLAG] == '0);

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/i2cst_irq_gate.sv
module i2cst_irq_gate #(
    parameter int NFLAG = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] flags_i,
    input  logic [NFLAG-1:0] mask_i,
    output logic             irq_o
);
    logic irq_d, irq_q;

    always_comb irq_d = |(flags_i & mask_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_i & mask_i) == '0) |=> !irq_o);

    // R10
    irq_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_i & mask_i) != '0) |=> irq_o);
endmodule

// File: rtl/i2c_stat_irq.sv
module i2c_stat_irq
    import i2cst_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 4,
    parameter int STAT_ADDR = 0,
    parameter int MASK_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_rst,
    input  logic              loopback,
    input  logic              scl_in,
    input  logic              ev_arb_lost,
    input  logic              ev_nack_rx,
    input  logic              ev_acc_rdy,
    input  logic              ev_rx_rdy,
    input  logic              ev_tx_rdy,
    input  logic              ev_stop,
    input  logic              ev_start,
    input  logic              ev_slv_tx,
    input  logic              ev_tx_undr,
    input  logic              ev_rx_ovr,
    input  logic              ev_nack_tx,
    input  logic              tx_wr,
    input  logic              rx_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [NFLAG-1:0] flags, w1c, mask;
    logic [NFLAG-1:0] set_v;
    flag_ctl_t        ctl [NFLAG];

    always_comb begin
        set_v          = '0;
        set_v[F_ARB]   = ev_arb_lost;
        set_v[F_NKRX]  = ev_nack_rx;
        set_v[F_ACC]   = ev_acc_rdy;
        set_v[F_RXRDY] = ev_rx_rdy;
        set_v[F_TXRDY] = ev_tx_rdy;
        set_v[F_STOP]  = ev_stop;
        set_v[F_SLV]   = ev_slv_tx;
        set_v[F_TXEMP] = ev_tx_undr;
        set_v[F_OVR]   = ev_rx_ovr;
        set_v[F_BUSY]  = ev_start;
        set_v[F_NKTX]  = ev_nack_tx;

        for (int i = 0; i < NFLAG; i++) begin
            ctl[i].set      = set_v[i];
            ctl[i].clr      = w1c[i] & W1C_MASK[i];
            ctl[i].load     = mod_rst;
            ctl[i].load_val = RST_VAL[i];
        end

        ctl[F_SLV].clr       = ctl[F_SLV].clr | ev_start | ev_stop;
        ctl[F_SLV].load      = mod_rst | loopback;
        ctl[F_SLV].load_val  = 1'b0;

        ctl[F_BUSY].clr      = ctl[F_BUSY].clr | ev_stop;
        ctl[F_BUSY].load_val = ~scl_in;

        ctl[F_OVR].clr       = rx_rd;
        ctl[F_TXEMP].clr     = tx_wr;
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        i2cst_flag_cell #(.RESET_BIT(RST_VAL[g])) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl_i (ctl[g]),
            .q_o   (flags[g])
        );
    end

    i2cst_bus_if #(
        .NFLAG(NFLAG), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
    ) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr),
        .wr_i    (bus_wr),
        .wdata_i (bus_wdata),
        .rd_i    (bus_rd),
        .flags_i (flags),
        .w1c_o   (w1c),
        .mask_o  (mask),
        .rdata_o (bus_rdata)
    );

    i2cst_irq_gate #(.NFLAG(NFLAG)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags),
        .mask_i  (mask),
        .irq_o   (irq)
    );

    // R4
    loop_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loopback |=> !flags[F_SLV]);

    // R5
    nack_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_nack_tx && !mod_rst) |=> flags[F_NKTX]);

    // R6
    busy_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_rst && !scl_in) |=> flags[F_BUSY]);

    // R7
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !ev_rx_ovr) |=> !flags[F_OVR]);

    // R8
    txemp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_undr |=> flags[F_TXEMP]);
endmodule

// File: tb/i2c_stat_irq_tb.sv
module i2c_stat_irq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mod_rst = 0, loopback = 0, scl_in = 1;
    logic ev_arb_lost = 0, ev_nack_rx = 0, ev_acc_rdy = 0, ev_rx_rdy = 0, ev_tx_rdy = 0;
    logic ev_stop = 0, ev_start = 0, ev_slv_tx = 0, ev_tx_undr = 0, ev_rx_ovr = 0, ev_nack_tx = 0;
    logic tx_wr = 0, rx_rd = 0;
    logic [3:0]  bus_addr = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic        irq;

    int total = 0, bad = 0;
    bit done = 0;
    string tag = "R1";

    logic [10:0] mflag = 11'h090, mmask = 0;
    logic [15:0] mrd = 0;
    logic        mirq = 0;

    always #2 clk = ~clk;

    i2c_stat_irq u_dut (.*);

    task automatic drop_pulses();
        ev_arb_lost = 0; ev_nack_rx = 0; ev_acc_rdy = 0; ev_rx_rdy = 0; ev_tx_rdy = 0;
        ev_stop = 0; ev_start = 0; ev_slv_tx = 0; ev_tx_undr = 0; ev_rx_ovr = 0;
        ev_nack_tx = 0; tx_wr = 0; rx_rd = 0; bus_wr = 0; bus_rd = 0;
    endtask

    task automatic compare();
        total++;
        if (bus_rdata !== mrd) begin
            bad++;
            $display("FAIL %s rdata act=%h exp=%h", tag, bus_rdata, mrd);
        end
        total++;
        if (irq !== mirq) begin
            bad++;
            $display("FAIL %s irq act=%b exp=%b", tag, irq, mirq);
        end
    endtask

    // behavioural next-state model, applied at the edge the inputs are captured
    task automatic tick();
        logic [10:0] f;
        logic [15:0] r;
        f = mflag;
        if (bus_wr && bus_addr == 0) f = f & ~(bus_wdata[10:0] & 11'h67F);
        if (ev_start || ev_stop) f[6] = 0;
        if (ev_stop) f[9] = 0;
        if (tx_wr) f[7] = 0;
        if (rx_rd) f[8] = 0;
        f = f | {ev_nack_tx, ev_start, ev_rx_ovr, ev_tx_undr, ev_slv_tx, ev_stop,
                 ev_tx_rdy, ev_rx_rdy, ev_acc_rdy, ev_nack_rx, ev_arb_lost};
        if (mod_rst) begin
            f = 11'h090;
            f[9] = !scl_in;
        end
        if (loopback) f[6] = 0;
        r = mrd;
        if (bus_rd) r = (bus_addr == 0) ? {5'd0, mflag} : (bus_addr == 1) ? {5'd0, mmask} : 16'd0;
        mirq = |(mflag & mmask);
        if (bus_wr && bus_addr == 1) mmask = bus_wdata[10:0];
        mrd = r;
        mflag = f;
        @(negedge clk);
        compare();
        drop_pulses();
    endtask

    task automatic rd(input logic [3:0] a);
        bus_rd = 1; bus_addr = a; tick();
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d; tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare();
        // R1 reset values
        tag = "R1"; rd(0); rd(1); rd(2);
        // R2 write-one-to-clear, zero writes, read-only and reserved bits
        tag = "R2";
        ev_arb_lost = 1; ev_nack_rx = 1; ev_acc_rdy = 1; ev_rx_rdy = 1; ev_rx_ovr = 1; tick();
        rd(0);
        wr(0, 16'h0000); rd(0);
        wr(0, 16'hFFFF); rd(0);
        rd(5);
        // R3 set beats clear in the same cycle
        tag = "R3";
        ev_arb_lost = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 16'h0001; tick(); rd(0);
        ev_rx_ovr = 1; rx_rd = 1; tick(); rd(0);
        // R4 slave transmit flag
        tag = "R4";
        ev_slv_tx = 1; tick(); rd(0);
        ev_start = 1; tick(); rd(0);
        ev_slv_tx = 1; tick(); ev_stop = 1; tick(); rd(0);
        loopback = 1; ev_slv_tx = 1; tick(); rd(0); loopback = 0; tick();
        // R5 NACK sent
        tag = "R5";
        ev_nack_tx = 1; tick(); ev_start = 1; tick(); ev_stop = 1; tick(); rd(0);
        wr(0, 16'h0400); rd(0);
        // R6 bus busy
        tag = "R6";
        ev_start = 1; tick(); rd(0); ev_stop = 1; tick(); rd(0);
        ev_start = 1; tick(); wr(0, 16'h0200); rd(0);
        mod_rst = 1; scl_in = 0; tick(); rd(0); scl_in = 1; tick(); rd(0); mod_rst = 0; tick();
        // R7 overrun and simple set events
        tag = "R7";
        ev_rx_ovr = 1; tick(); rd(0); rx_rd = 1; tick(); rd(0);
        ev_tx_rdy = 1; ev_stop = 1; tick(); rd(0);
        // R8 transmit empty
        tag = "R8";
        tx_wr = 1; tick(); rd(0); ev_tx_undr = 1; tick(); rd(0); tx_wr = 1; ev_tx_undr = 1; tick(); rd(0);
        // R9 module reset
        tag = "R9";
        wr(1, 16'h07FF);
        ev_nack_tx = 1; ev_arb_lost = 1; ev_rx_ovr = 1; tick();
        mod_rst = 1; scl_in = 0; ev_arb_lost = 1; tick(); rd(0); rd(1); mod_rst = 0; scl_in = 1; tick();
        // R10 interrupt masking
        tag = "R10";
        wr(0, 16'hFFFF); wr(1, 16'h0000); ev_arb_lost = 1; tick(); tick(); tick();
        wr(1, 16'h0001); tick(); tick(); wr(0, 16'h0001); tick(); tick();
        wr(1, 16'h0080); tick(); tick();
        // R11 read timing and hold
        tag = "R11";
        rd(0); ev_nack_rx = 1; tick(); tick(); rd(0); rd(1);
        bus_rd = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 16'h0002; tick(); rd(0);
        // random mix across all requirements
        tag = "R3";
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            ev_arb_lost = r[0] & r[1]; ev_nack_rx = r[2] & r[3]; ev_acc_rdy = r[4] & r[5];
            ev_rx_rdy = r[6] & r[7]; ev_tx_rdy = r[8] & r[9]; ev_stop = r[10] & r[11] & r[12];
            ev_start = r[13] & r[14] & r[15]; ev_slv_tx = r[16] & r[17]; ev_tx_undr = r[18] & r[19];
            ev_rx_ovr = r[20] & r[21]; ev_nack_tx = r[22] & r[23]; tx_wr = r[24] & r[25];
            rx_rd = r[26] & r[27];
            r = $urandom;
            bus_rd = r[0] | r[1];
            bus_wr = r[2] & r[3];
            bus_addr = (r[4] & r[5]) ? 4'(r[7:6]) : 4'd0;
            bus_wdata = 16'($urandom);
            if (r[15:10] == 0) mod_rst = ~mod_rst;
            if (r[21:16] == 0) loopback = ~loopback;
            if (r[24:22] == 0) scl_in = ~scl_in;
            tick();
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule